// File: doc/BRIEF.md
# Fragmenting Mailbox Send Engine

This block pushes a byte message into a slot-based mailbox shared with a peer processor. Each slot holds 32 bits. A request gives a byte length and two 8-bit addresses, one for the local endpoint and one for the remote client. The engine fetches the message bytes by index from a byte source. It splits the message into fragments. Each fragment is one header slot followed by its payload slots. After each fragment the engine rings the peer's doorbell.

The size of a fragment is limited by two things: the mailbox depth and the 9-bit length field in the header. One slot of the mailbox is always reserved for the header. Only the last fragment of a message is marked complete. Before each header, and again before each payload, the engine waits until the mailbox reports enough free slots.

If the peer is not ready, the whole message is sent again from byte zero. A wait that lasts longer than a programmable number of cycles has the same effect. The engine makes a fixed number of attempts and then reports an error.

Top module: `mbox_frag_tx`

## Requirements
- R1: A start pulse with a zero length is rejected. `error` is high for exactly the one cycle after the start edge. No slot is written and `intClr` stays low.
- R2: The header slot is laid out as follows: client address in bits 7:0, local address in bits 15:8, fragment byte length in bits 24:16, completion flag in bit 31. Bits 30:25 are zero.
- R3: A fragment carries min(P, remaining) bytes, where P = min(4*depth, 511) - 4. Here `depth` is the mailbox depth in slots.
- R4: The completion flag is 1 only in the header of the fragment that carries the last bytes of the message.
- R5: No header is written while `freeSlots` is 0. No payload slot of a fragment is written until `freeSlots` is at least ceil(fragment length / 4).
- R6: Payload bytes are packed into slots little-endian. The lowest-indexed byte goes in bits 7:0. In a final partial slot, the unused upper bytes are zero.
- R7: `doorbell` pulses for one cycle, in the cycle directly after the last payload slot of each fragment is written.
- R8: If `peerReady` is low in the cycle after the doorbell, the attempt fails. The next attempt resends the whole message from byte 0, starting with the first fragment's header.
- R9: Each attempt first waits for `peerReady`. Any wait (peer ready, header space, payload space) that exceeds `timeoutCycles` cycles fails the attempt. After 5 failed attempts, `error` pulses for one cycle and no further slot is written.
- R10: For each accepted message, `intClr` pulses once, for one cycle, in the cycle after the start edge.
- R11: On success, `done` pulses for one cycle after the last fragment's check. `done` and `error` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse; ignored while a message is in progress |
| msgLen | input | LEN_W | Message length in bytes, sampled at start |
| hostAddr | input | 8 | Local endpoint address, sampled at start |
| clientAddr | input | 8 | Remote client address, sampled at start |
| depth | input | DEPTH_W | Mailbox depth in slots (at least 2) |
| freeSlots | input | DEPTH_W | Free slots currently reported by the mailbox |
| peerReady | input | 1 | Peer ready flag |
| timeoutCycles | input | TO_W | Maximum number of cycles spent in any wait |
| rdIdx | output | LEN_W | Index of the message byte being fetched |
| rdByte | input | 8 | Message byte at `rdIdx`, same cycle |
| slotWr | output | 1 | Slot write strobe |
| slotData | output | 32 | Slot write data |
| doorbell | output | 1 | One-cycle doorbell pulse to the peer |
| intClr | output | 1 | One-cycle pulse that clears the local interrupt status |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure pulse |

## Verification
The immediate results have fixed timing after the start edge. `error` for a rejected zero-length start, and `intClr` for an accepted start, are both high in the single cycle after that edge. The bench samples them at the following negative edge, and checks again one cycle later that they have dropped.

The timing of slot writes, doorbells and `done` depends on the waits. For these, a monitor logs every strobe at negative edges. The bench then compares the logged slot sequence word by word against headers and packed payloads that it computes from the fragment rule.

For the wait rules, the bench holds `freeSlots` or `peerReady` low for a known number of cycles. It checks the write count while the wait is still in force, and again after the wait is released.

// File: rtl/mbox_frag_pkg.sv
package mbox_frag_pkg;
  localparam int HDR_LEN_W = 9;
  localparam int SLOT_BYTES = 4;
  localparam int NEED_W = HDR_LEN_W - 2;

  // strobes from the control to the datapath
  typedef struct packed {
    logic accept;
    logic loadMsg;
    logic fragStart;
    logic byteTake;
    logic fragAdvance;
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDY, ST_HDR, ST_PAY, ST_SEND, ST_BELL, ST_CHK
  } txState_t;
endpackage

// File: rtl/mbox_frag_dp.sv
module mbox_frag_dp
  import mbox_frag_pkg::*;
#(
  parameter int LEN_W = 12,
  parameter int DEPTH_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpCtl_t               ctl,
  input  logic [LEN_W-1:0]     msgLen,
  input  logic [7:0]           hostAddr,
  input  logic [7:0]           clientAddr,
  input  logic [DEPTH_W-1:0]   depth,
  input  logic [7:0]           rdByte,
  output logic [LEN_W-1:0]     rdIdx,
  output logic                 slotWr,
  output logic [31:0]          slotData,
  output logic [NEED_W-1:0]    needSlots,
  output logic                 lastByte,
  output logic                 msgDone
);
  localparam int CAP_W = DEPTH_W + 2;
  localparam int LEN_LIMIT = (1 << HDR_LEN_W) - 1;

  logic [LEN_W-1:0]     lenQ, remQ, idxQ;
  logic [7:0]           hostQ, clientQ;
  logic [HDR_LEN_W-1:0] maxPayQ, fragLenQ, fragCntQ;
  logic [1:0]           laneQ;
  logic [31:0]          packQ;

  logic [CAP_W-1:0]     capBytes;
  logic [HDR_LEN_W-1:0] capped, maxPayC, curFrag;
  logic                 lastFrag, payWr;
  logic [31:0]          hdrWord, payWord;
  logic [HDR_LEN_W:0]   roundUp;

  // payload ceiling: buffer bytes or length-field limit, minus the header slot
  always_comb begin
    capBytes = {depth, 2'b00};
    capped   = (capBytes > CAP_W'(LEN_LIMIT)) ? HDR_LEN_W'(LEN_LIMIT) : capBytes[HDR_LEN_W-1:0];
    maxPayC  = capped - HDR_LEN_W'(SLOT_BYTES);
  end

  always_comb begin
    curFrag  = (remQ < LEN_W'(maxPayQ)) ? remQ[HDR_LEN_W-1:0] : maxPayQ;
    lastFrag = (LEN_W'(curFrag) == remQ);
    hdrWord  = {lastFrag, 6'b0, curFrag, hostQ, clientQ};
    payWord  = packQ | (32'(rdByte) << {laneQ, 3'b000});
    roundUp  = {1'b0, fragLenQ} + (HDR_LEN_W+1)'(SLOT_BYTES - 1);
    needSlots = roundUp[HDR_LEN_W:2];
    lastByte = (fragCntQ == fragLenQ - 1'b1);
    msgDone  = (LEN_W'(fragLenQ) == remQ);
    payWr    = ctl.byteTake & ((laneQ == 2'd3) | lastByte);
    slotWr   = ctl.fragStart | payWr;
    slotData = ctl.fragStart ? hdrWord : payWord;
    rdIdx    = idxQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lenQ <= '0; remQ <= '0; idxQ <= '0; hostQ <= '0; clientQ <= '0;
      maxPayQ <= '0; fragLenQ <= '0; fragCntQ <= '0; laneQ <= '0; packQ <= '0;
    end else begin
      if (ctl.accept) begin
        lenQ    <= msgLen;
        hostQ   <= hostAddr;
        clientQ <= clientAddr;
      end
      if (ctl.loadMsg) begin
        remQ    <= lenQ;
        idxQ    <= '0;
        maxPayQ <= maxPayC;
      end
      if (ctl.fragStart) begin
        fragLenQ <= curFrag;
        fragCntQ <= '0;
        laneQ    <= '0;
        packQ    <= '0;
      end
      if (ctl.byteTake) begin
        idxQ     <= idxQ + 1'b1;
        fragCntQ <= fragCntQ + 1'b1;
        laneQ    <= laneQ + 1'b1;
        packQ    <= payWr ? 32'b0 : payWord;
      end
      if (ctl.fragAdvance) remQ <= remQ - LEN_W'(fragLenQ);
    end
  end

  // R3: a fragment is never empty and never exceeds the 9-bit field minus a slot
  a_r3_frag_cap: assert property (@(posedge clk) disable iff (!rstN)
    ctl.fragStart |-> (curFrag != '0 && curFrag <= HDR_LEN_W'(LEN_LIMIT - SLOT_BYTES)));
  // R6: the byte index only moves while payload is being taken
  a_r6_idx_moves_on_take: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(ctl.byteTake) && !$past(ctl.loadMsg)) |-> $stable(idxQ));
endmodule

// File: rtl/mbox_frag_ctl.sv
module mbox_frag_ctl
  import mbox_frag_pkg::*;
#(
  parameter int MAX_TRY = 5,
  parameter int TO_W = 16,
  parameter int DEPTH_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic               lenZero,
  input  logic               peerReady,
  input  logic [DEPTH_W-1:0] freeSlots,
  input  logic [NEED_W-1:0]  needSlots,
  input  logic               lastByte,
  input  logic               msgDone,
  input  logic [TO_W-1:0]    timeoutCycles,
  output dpCtl_t             ctl,
  output logic               intClr,
  output logic               doorbell,
  output logic               done,
  output logic               error
);
  localparam int TRY_W = $clog2(MAX_TRY + 1);
  localparam int CMP_W = (DEPTH_W > NEED_W) ? DEPTH_W : NEED_W;

  txState_t         stateQ, nxt;
  logic [TRY_W-1:0] tryQ;
  logic [TO_W-1:0]  timerQ;
  logic             expire, waiting, failAtt, lastTry, doneD, errD;

  always_comb begin
    waiting = (stateQ == ST_RDY) || (stateQ == ST_HDR) || (stateQ == ST_PAY);
    expire  = waiting && (timerQ >= timeoutCycles);
    lastTry = (tryQ == TRY_W'(MAX_TRY - 1));
  end

  always_comb begin
    nxt = stateQ; ctl = '0; failAtt = 1'b0; doneD = 1'b0; errD = 1'b0;
    case (stateQ)
      ST_IDLE: if (start) begin
        if (lenZero) errD = 1'b1;
        else begin ctl.accept = 1'b1; nxt = ST_RDY; end
      end
      ST_RDY: if (peerReady) begin ctl.loadMsg = 1'b1; nxt = ST_HDR; end
              else if (expire) failAtt = 1'b1;
      ST_HDR: if (freeSlots != '0) begin ctl.fragStart = 1'b1; nxt = ST_PAY; end
              else if (expire) failAtt = 1'b1;
      ST_PAY: if (CMP_W'(freeSlots) >= CMP_W'(needSlots)) nxt = ST_SEND;
              else if (expire) failAtt = 1'b1;
      ST_SEND: begin ctl.byteTake = 1'b1; if (lastByte) nxt = ST_BELL; end
      ST_BELL: nxt = ST_CHK;
      ST_CHK: if (!peerReady) failAtt = 1'b1;
              else if (msgDone) begin doneD = 1'b1; nxt = ST_IDLE; end
              else begin ctl.fragAdvance = 1'b1; nxt = ST_HDR; end
      default: nxt = ST_IDLE;
    endcase
    if (failAtt) begin
      if (lastTry) begin errD = 1'b1; nxt = ST_IDLE; end
      else nxt = ST_RDY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE; tryQ <= '0; timerQ <= '0;
      intClr <= 1'b0; done <= 1'b0; error <= 1'b0;
    end else begin
      stateQ <= nxt;
      timerQ <= (nxt != stateQ || failAtt) ? '0 : (waiting ? timerQ + 1'b1 : timerQ);
      if (ctl.accept) tryQ <= '0;
      else if (failAtt && !lastTry) tryQ <= tryQ + 1'b1;
      intClr <= ctl.accept;
      done   <= doneD;
      error  <= errD;
    end
  end

  assign doorbell = (stateQ == ST_BELL);

  // R9: attempt counter stays within the retry budget
  a_r9_try_bound: assert property (@(posedge clk) disable iff (!rstN) tryQ < TRY_W'(MAX_TRY));
  // R11: success and failure are exclusive; success is a single pulse
  a_r11_done_err_excl: assert property (@(posedge clk) disable iff (!rstN) !(done && error));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
endmodule

// File: rtl/mbox_frag_tx.sv
module mbox_frag_tx
  import mbox_frag_pkg::*;
#(
  parameter int LEN_W = 12,     // at least 9
  parameter int DEPTH_W = 8,    // at least 7
  parameter int TO_W = 16,
  parameter int MAX_TRY = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [LEN_W-1:0]   msgLen,
  input  logic [7:0]         hostAddr,
  input  logic [7:0]         clientAddr,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [DEPTH_W-1:0] freeSlots,
  input  logic               peerReady,
  input  logic [TO_W-1:0]    timeoutCycles,
  output logic [LEN_W-1:0]   rdIdx,
  input  logic [7:0]         rdByte,
  output logic               slotWr,
  output logic [31:0]        slotData,
  output logic               doorbell,
  output logic               intClr,
  output logic               done,
  output logic               error
);
  dpCtl_t            ctl;
  logic [NEED_W-1:0] needSlots;
  logic              lastByte, msgDone;

  mbox_frag_ctl #(.MAX_TRY(MAX_TRY), .TO_W(TO_W), .DEPTH_W(DEPTH_W)) uCtl (
    .clk(clk), .rstN(rstN), .start(start), .lenZero(msgLen == '0),
    .peerReady(peerReady), .freeSlots(freeSlots), .needSlots(needSlots),
    .lastByte(lastByte), .msgDone(msgDone), .timeoutCycles(timeoutCycles),
    .ctl(ctl), .intClr(intClr), .doorbell(doorbell), .done(done), .error(error));

  mbox_frag_dp #(.LEN_W(LEN_W), .DEPTH_W(DEPTH_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .msgLen(msgLen), .hostAddr(hostAddr),
    .clientAddr(clientAddr), .depth(depth), .rdByte(rdByte), .rdIdx(rdIdx),
    .slotWr(slotWr), .slotData(slotData), .needSlots(needSlots),
    .lastByte(lastByte), .msgDone(msgDone));

  // R7: the doorbell directly follows a slot write (the fragment's last payload slot)
  a_r7_bell_after_write: assert property (@(posedge clk) disable iff (!rstN)
    doorbell |-> $past(slotWr));
  a_r7_bell_pulse: assert property (@(posedge clk) disable iff (!rstN) doorbell |=> !doorbell);
  // R10: interrupt-status clear is a single pulse
  a_r10_intclr_pulse: assert property (@(posedge clk) disable iff (!rstN) intClr |=> !intClr);
endmodule

// File: tb/sim_mbox_frag_tx.sv
module sim_mbox_frag_tx;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W = 12;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0, peerReady = 1'b0;
  logic [LEN_W-1:0] msgLen = '0, rdIdx;
  logic [7:0] hostAddr = '0, clientAddr = '0, depth = 8'd8, freeSlots = 8'd255, rdByte;
  logic [15:0] timeoutCycles = 16'd100;
  logic slotWr, doorbell, intClr, done, error;
  logic [31:0] slotData;

  int nChk = 0, nBad = 0, cyc = 0;
  int wrN = 0, bellN = 0, clrN = 0, doneN = 0, errN = 0;
  logic [31:0] wlog [0:511];
  logic dropArm = 1'b0;
  int lowCnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign rdByte = 8'(32'(rdIdx) * 7 + 3);

  mbox_frag_tx u0 (.clk(clk), .rstN(rstN), .start(start), .msgLen(msgLen),
    .hostAddr(hostAddr), .clientAddr(clientAddr), .depth(depth), .freeSlots(freeSlots),
    .peerReady(peerReady), .timeoutCycles(timeoutCycles), .rdIdx(rdIdx), .rdByte(rdByte),
    .slotWr(slotWr), .slotData(slotData), .doorbell(doorbell), .intClr(intClr),
    .done(done), .error(error));

  function automatic logic [7:0] srcByte(int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: log strobes at negative edges; optional peer drop after a doorbell
  always @(negedge clk) begin
    if (slotWr && wrN < 512) begin wlog[wrN] = slotData; wrN++; end
    if (doorbell) bellN++;
    if (intClr) clrN++;
    if (done) doneN++;
    if (error) errN++;
    if (dropArm && doorbell) begin peerReady = 1'b0; dropArm = 1'b0; lowCnt = 3; end
    else if (lowCnt > 0) begin lowCnt--; if (lowCnt == 0) peerReady = 1'b1; end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual %0d expected below 150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  task automatic clearLog();
    wrN = 0; bellN = 0; clrN = 0; doneN = 0; errN = 0;
  endtask

  task automatic kick(input int len, input int hst, input int cli);
    @(negedge clk);
    clearLog();
    msgLen = LEN_W'(len); hostAddr = 8'(hst); clientAddr = 8'(cli); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitEnd();
    for (int i = 0; i < 5000 && (doneN + errN) == 0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // walk the expected slot stream for one full attempt starting at log index base
  task automatic chkFrags(input int len, input int dep, input int hst, input int cli,
                          input int base, output int used, output int frags);
    int rem, pos, k, maxp, f, cap;
    logic [31:0] hdr, w;
    rem = len; pos = 0; k = base; frags = 0;
    cap = dep * 4; if (cap > 511) cap = 511;
    maxp = cap - 4;
    while (rem > 0) begin
      f = (rem < maxp) ? rem : maxp;
      hdr = {(f == rem), 6'b0, 9'(f), 8'(hst), 8'(cli)};
      check(wlog[k] === hdr, "R2 R3 R4 header", wlog[k], hdr);
      k++;
      for (int s = 0; s < (f + 3) / 4; s++) begin
        w = '0;
        for (int b = 0; b < 4; b++)
          if (s * 4 + b < f) w[b*8 +: 8] = srcByte(pos + s * 4 + b);
        check(wlog[k] === w, "R6 payload", wlog[k], w);
        k++;
      end
      pos += f; rem -= f; frags++;
    end
    used = k - base;
  endtask

  task automatic runAndCheck(input int len, input int dep, input string tag);
    int used, frags;
    depth = 8'(dep); freeSlots = 8'd255; peerReady = 1'b1;
    kick(len, 8'h21, 8'h07);
    check(intClr === 1'b1, "R10 intClr after start", 32'(intClr), 1);
    @(negedge clk);
    check(intClr === 1'b0, "R10 intClr single", 32'(intClr), 0);
    waitEnd();
    chkFrags(len, dep, 8'h21, 8'h07, 0, used, frags);
    check(wrN == used, {tag, " R5 slot count"}, 32'(wrN), 32'(used));
    check(bellN == frags, {tag, " R7 doorbells"}, 32'(bellN), 32'(frags));
    check(doneN == 1 && errN == 0, {tag, " R11 done once"}, 32'(doneN), 1);
    check(clrN == 1, {tag, " R10 one clear"}, 32'(clrN), 1);
  endtask

  task automatic tReset();
    check({slotWr, doorbell, intClr, done, error} === 5'b0, "R11 reset outputs",
          32'({slotWr, doorbell, intClr, done, error}), 0);
  endtask

  task automatic tZeroLen();
    peerReady = 1'b1;
    kick(0, 1, 2);
    check(error === 1'b1, "R1 error pulse", 32'(error), 1);
    check(intClr === 1'b0, "R1 no intClr", 32'(intClr), 0);
    @(negedge clk);
    check(error === 1'b0, "R1 error single cycle", 32'(error), 0);
    repeat (5) @(negedge clk);
    check(wrN == 0, "R1 no writes", 32'(wrN), 0);
  endtask

  task automatic tSlotWait();
    int used, frags;
    depth = 8'd8; freeSlots = 8'd0; peerReady = 1'b1;
    kick(8, 3, 4);
    repeat (20) @(negedge clk);
    check(wrN == 0, "R5 header held while full", 32'(wrN), 0);
    freeSlots = 8'd1;
    repeat (10) @(negedge clk);
    check(wrN == 1, "R5 payload held for 2 slots", 32'(wrN), 1);
    freeSlots = 8'd2;
    waitEnd();
    check(wrN == 3 && doneN == 1, "R5 completes after space", 32'(wrN), 3);
    chkFrags(8, 8, 3, 4, 0, used, frags);
  endtask

  task automatic tPeerDrop();
    int u1, u2, f1, f2;
    depth = 8'd8; freeSlots = 8'd255; peerReady = 1'b1; dropArm = 1'b1;
    kick(6, 9, 10);
    waitEnd();
    chkFrags(6, 8, 9, 10, 0, u1, f1);
    chkFrags(6, 8, 9, 10, u1, u2, f2);
    check(wrN == u1 + u2, "R8 whole message resent", 32'(wrN), 32'(u1 + u2));
    check(bellN == 2 && doneN == 1, "R8 two doorbells then done", 32'(bellN), 2);
  endtask

  task automatic tNeverReady();
    int t0;
    depth = 8'd8; peerReady = 1'b0; timeoutCycles = 16'd20;
    t0 = cyc;
    kick(5, 1, 1);
    waitEnd();
    check(errN == 1 && doneN == 0, "R9 error after retries", 32'(errN), 1);
    check(wrN == 0, "R9 no writes without peer", 32'(wrN), 0);
    check(cyc - t0 >= 5 * 20, "R9 five timed attempts", 32'(cyc - t0), 100);
    check(clrN == 1, "R10 clear only once over retries", 32'(clrN), 1);
    timeoutCycles = 16'd100;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tZeroLen();
    runAndCheck(6, 8, "single");
    runAndCheck(30, 4, "R3 depth-limited");
    runAndCheck(600, 200, "R3 field-limited");
    runAndCheck(12, 4, "R4 exact fit");
    tSlotWait();
    tPeerDrop();
    tNeverReady();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule